// File: doc/BRIEF.md
# Column Sparse-Scan Hit Readout

This block takes the per-pixel trigger-match flags of a pixel matrix and reads out only the flagged pixels. A trigger strobe copies the flags of every idle column into the block, together with the trigger time stamp. Each column then issues one flagged row address per clock into its own end-of-column FIFO and clears that pixel's flag. Empty pixels cost no cycles. All columns scan independently and at the same time.

Every column has a pixel clear output. It pulses for the pixel being served, so the pixel can drop its own flag. A column whose FIFO is full stops and waits for the consumer. A column that is still scanning ignores a new trigger. Per-column and global done outputs show when scanning has finished, and the FIFO ports let a downstream serialiser drain each column.

Top module: `hit_scan_readout`

## Requirements
- R1: When `load_i` is high at a clock edge and a column has no pending flags, that column copies its slice of `match_i` and `load_ts_i`. If the copied slice is non-zero, its `col_done_o` bit is low after that edge.
- R2: While a column has pending flags and its FIFO is not full, it writes exactly one address into its FIFO at every clock edge. Rows are served in ascending index order, with row 0 at the top and served first.
- R3: Each FIFO word is {time stamp, row}. The row sits in the low ROW_W = clog2(N_ROWS) bits and the time stamp captured at load sits in the TS_W bits above it. Column c uses `rd_data_o[c*W +: W]`.
- R4: `clear_o` bit c*N_ROWS+row is high during the cycle in which that pixel's address is written. At most one bit per column is high.
- R5: Columns scan in parallel. A column's output does not depend on the flags of any other column.
- R6: While a column's FIFO is full, no address is written, no flag is cleared and its `clear_o` slice is zero.
- R7: `col_done_o[c]` is high exactly when column c has no pending flags. `done_o` is high when every column is done. After reset all are high.
- R8: A load that arrives while a column still has pending flags is ignored by that column: neither its flags nor its time stamp change.
- R9: Each FIFO returns words in write order. `empty_o[c]` is high when the FIFO holds nothing. A pop (`pop_i[c]`) on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Trigger strobe: copy the flags into idle columns |
| load_ts_i | input | TS_W | Time stamp of the trigger |
| match_i | input | N_COLS*N_ROWS | Pixel match flags, bit c*N_ROWS+row |
| clear_o | output | N_COLS*N_ROWS | Clear pulse to the pixel being served |
| pop_i | input | N_COLS | FIFO read strobe per column |
| rd_data_o | output | N_COLS*(TS_W+ROW_W) | FIFO head word per column |
| empty_o | output | N_COLS | FIFO empty per column |
| col_done_o | output | N_COLS | Column has no pending flags |
| done_o | output | 1 | All columns done |

## Verification
A load taken at edge k lowers `col_done_o` after edge k. The first `clear_o` pulse is visible in the cycle that follows that edge, and the first word reaches the FIFO head after edge k+1. After that, one word arrives per edge until the column is done or its FIFO is full. The bench drives inputs and samples outputs at the falling edge. It checks `clear_o` and `col_done_o` in the first cycle after the load, and checks done only after enough cycles for the longest column. The drain task compares the head word before each pop, so the result does not depend on how long the scan takes.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/hsr_prio_enc.sv
// Lowest set index wins (top row first).
module hsr_prio_enc #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          valid_o
);
  always_comb begin
    idx_o   = '0;
    valid_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o   = IW'(i);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsr_eoc_fifo.sv
module hsr_eoc_fifo #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = hsr_pkg::idx_bits(DEPTH);
  localparam int unsigned CW = hsr_pkg::idx_bits(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end
endmodule

// File: rtl/hsr_col_scan.sv
module hsr_col_scan #(
  parameter int unsigned N_ROWS = 16,
  parameter int unsigned TS_W   = 8,
  parameter int unsigned ROW_W  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [TS_W-1:0]         ts_i,
  input  logic [N_ROWS-1:0]       match_i,
  input  logic                    full_i,
  output logic                    push_o,
  output logic [TS_W+ROW_W-1:0]   word_o,
  output logic [N_ROWS-1:0]       clear_o,
  output logic                    done_o
);
  logic [N_ROWS-1:0] flags_q;
  logic [TS_W-1:0]   ts_q;
  logic [ROW_W-1:0]  row;
  logic              any;

  hsr_prio_enc #(.N(N_ROWS), .IW(ROW_W)) u_enc (
    .req_i  (flags_q),
    .idx_o  (row),
    .valid_o(any)
  );

  assign push_o  = any & ~full_i;
  assign clear_o = push_o ? (N_ROWS'(1) << row) : '0;
  assign word_o  = {ts_q, row};
  assign done_o  = ~any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      ts_q    <= '0;
    end else if (!any) begin
      if (load_i) begin
        flags_q <= match_i;
        ts_q    <= ts_i;
      end
    end else if (push_o) begin
      flags_q <= flags_q & ~clear_o;
    end
  end
endmodule

// File: rtl/hit_scan_readout.sv
module hit_scan_readout #(
  parameter int unsigned N_COLS     = 4,
  parameter int unsigned N_ROWS     = 16,
  parameter int unsigned TS_W       = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned ROW_W     = hsr_pkg::idx_bits(N_ROWS),
  localparam int unsigned W         = TS_W + ROW_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [TS_W-1:0]          load_ts_i,
  input  logic [N_COLS*N_ROWS-1:0] match_i,
  output logic [N_COLS*N_ROWS-1:0] clear_o,
  input  logic [N_COLS-1:0]        pop_i,
  output logic [N_COLS*W-1:0]      rd_data_o,
  output logic [N_COLS-1:0]        empty_o,
  output logic [N_COLS-1:0]        col_done_o,
  output logic                     done_o
);
  logic [N_COLS-1:0] col_full;
  logic [N_COLS-1:0] col_push;
  logic [W-1:0]      col_word [N_COLS];

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    hsr_col_scan #(.N_ROWS(N_ROWS), .TS_W(TS_W), .ROW_W(ROW_W)) u_scan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .ts_i   (load_ts_i),
      .match_i(match_i[c*N_ROWS +: N_ROWS]),
      .full_i (col_full[c]),
      .push_o (col_push[c]),
      .word_o (col_word[c]),
      .clear_o(clear_o[c*N_ROWS +: N_ROWS]),
      .done_o (col_done_o[c])
    );

    hsr_eoc_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (col_push[c]),
      .wdata_i(col_word[c]),
      .pop_i  (pop_i[c]),
      .rdata_o(rd_data_o[c*W +: W]),
      .empty_o(empty_o[c]),
      .full_o (col_full[c])
    );
  end

  assign done_o = &col_done_o;
endmodule

// File: rtl/hsr_chk.sv
module hsr_chk #(
  parameter int unsigned N_COLS = 4,
  parameter int unsigned N_ROWS = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     load_i,
  input logic [N_COLS*N_ROWS-1:0] clear_o,
  input logic [N_COLS-1:0]        col_done_o,
  input logic                     done_o,
  input logic [N_COLS-1:0]        col_full
);
  for (genvar c = 0; c < N_COLS; c++) begin : g_c
    AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(clear_o[c*N_ROWS +: N_ROWS])); // R4
    AST_NO_CLR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_full[c] |-> (clear_o[c*N_ROWS +: N_ROWS] == '0)); // R6
    AST_NO_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      col_done_o[c] |-> (clear_o[c*N_ROWS +: N_ROWS] == '0)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_done_o[c] && !load_i) |=> col_done_o[c]); // R7
    AST_BUSY_SERVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!col_done_o[c] && !col_full[c]) |-> (clear_o[c*N_ROWS +: N_ROWS] != '0)); // R2
  end
  AST_ALL_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o); // R7
endmodule

bind hit_scan_readout hsr_chk #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .clear_o   (clear_o),
  .col_done_o(col_done_o),
  .done_o    (done_o),
  .col_full  (col_full)
);

// File: tb/sim_hit_scan_readout.sv
`timescale 1ns/1ps
module sim_hit_scan_readout;
  localparam int NC = 4, NR = 16, TSW = 8, DEP = 4, RW = 4, W = TSW + RW;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0;
  logic [TSW-1:0] ts = '0;
  logic [NC*NR-1:0] match = '0, clear;
  logic [NC-1:0] pop = '0, empty, cdone;
  logic [NC*W-1:0] rdata;
  logic done;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hit_scan_readout #(.N_COLS(NC), .N_ROWS(NR), .TS_W(TSW), .FIFO_DEPTH(DEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_ts_i(ts), .match_i(match),
    .clear_o(clear), .pop_i(pop), .rd_data_o(rdata), .empty_o(empty),
    .col_done_o(cdone), .done_o(done));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic trig(input logic [NC*NR-1:0] m, input logic [TSW-1:0] t);
    @(negedge clk);
    match = m; ts = t; load = 1'b1;
    @(negedge clk);
    load = 1'b0; match = '0;
  endtask

  // Pop column c until done and empty, expecting rows of mask in ascending order.
  task automatic drain(input int c, input logic [NR-1:0] mask, input logic [TSW-1:0] t,
                       input string tag);
    int nxt = 0;
    int got = 0;
    int need = $countones(mask);
    for (int g = 0; g < 400; g++) begin
      if (!empty[c]) begin
        while (nxt < NR && !mask[nxt]) nxt++;
        check({tag, " R2 R3 word"}, 64'(rdata[c*W +: W]), 64'({t, RW'(nxt)}));
        nxt++; got++;
        pop[c] = 1'b1;
        @(negedge clk);
        pop[c] = 1'b0;
      end else if (cdone[c] && got >= need) begin
        break;
      end else begin
        @(negedge clk);
      end
    end
    check({tag, " R9 count"}, 64'(got), 64'(need));
    check({tag, " R9 empty"}, 64'(empty[c]), 64'd1);
  endtask

  task automatic t_reset;
    check("R7 reset done", 64'(done), 64'd1);
    check("R7 reset col_done", 64'(cdone), 64'hF);
    check("R9 reset empty", 64'(empty), 64'hF);
    check("R4 reset clear", clear, 64'd0);
  endtask

  task automatic t_basic;
    trig(64'h0003_0000_8000_0224, 8'h3C);
    check("R1 col_done after load", 64'(cdone), 64'b0100);
    check("R4 R5 first clears", clear, 64'h0001_0000_8000_0004);
    repeat (3) @(negedge clk);
    check("R7 global done", 64'(done), 64'd1);
    check("R5 idle column empty", 64'(empty[2]), 64'd1);
    drain(0, 16'h0224, 8'h3C, "basic c0");
    drain(1, 16'h8000, 8'h3C, "basic c1");
    drain(3, 16'h0003, 8'h3C, "basic c3");
  endtask

  task automatic t_stall_busy;
    trig(64'h0000_0000_0000_00FE, 8'h11);
    repeat (8) @(negedge clk);
    check("R6 stalled not done", 64'(cdone[0]), 64'd0);
    check("R6 stalled no clear", 64'(clear[15:0]), 64'd0);
    check("R6 fifo holds data", 64'(empty[0]), 64'd0);
    trig(64'h0000_0000_0008_0001, 8'h77);
    check("R8 R1 idle column accepts", 64'(cdone[1]), 64'd0);
    drain(0, 16'h00FE, 8'h11, "R8 busy c0");
    drain(1, 16'h0008, 8'h77, "R5 c1");
    check("R7 done after stall", 64'(done), 64'd1);
  endtask

  task automatic t_pop_empty;
    @(negedge clk);
    pop = '1;
    repeat (2) @(negedge clk);
    pop = '0;
    check("R9 pop on empty", 64'(empty), 64'hF);
    trig(64'h0000_0400_0000_0000, 8'hA5);
    repeat (2) @(negedge clk);
    drain(2, 16'h0400, 8'hA5, "R9 after empty pop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall_busy();
    t_pop_empty();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule